// File: doc/BRIEF.md
# Dual-View Aliased Register File

This block holds eight 80-bit entries that software reaches in two ways. The floating-point view treats the entries as a push-down stack. Each entry is addressed relative to a 3-bit top pointer. The packed-integer view treats the same storage as eight flat registers, each 64 bits wide, indexed directly. Packed accesses touch only the low 64-bit mantissa field of an entry. The upper 16-bit exponent field is forced to all ones when a packed write lands.

Each entry carries a 2-bit tag that says whether it holds a value. An empty command releases packed state so that stack use can start again cleanly. When a command from one view follows use of the other view, the block holds off that command for a fixed number of cycles to model the cost of switching.

Commands enter through a valid/ready channel, one per accepted cycle. A command that reads returns its result on a valid/ready response channel. The response stays in place until the consumer takes it. While a response is waiting and `rsp_ready` is low, no new command is accepted. That back-pressure carries straight through to `cmd_ready`.

Top module: `aliasreg_file`

## Requirements
- R1: After reset, the top pointer is 0, every tag reads 11 (empty, tags packed two bits per entry with entry k at bits 2k+1:2k), no response is pending, and `cmd_ready` is high.
- R2: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. Opcodes are 0 none, 1 push, 2 pop, 3 stack read, 4 stack write, 5 packed read, 6 packed write, 7 empty. Read-type commands (2, 3, 5) raise `rsp_valid` in the cycle after acceptance. The response holds `rsp_data` stable until `rsp_ready` is high, and `cmd_ready` stays low while a response waits with `rsp_ready` low.
- R3: Push decrements the top pointer modulo 8, stores all 80 bits of `cmd_data` at the new top, and sets that entry's tag to 00 (valid).
- R4: Pop returns the entry at the top pointer, sets its tag to 11, and increments the top pointer modulo 8.
- R5: Stack read and stack write reach physical entry (top + `cmd_idx`) mod 8. Stack write stores all 80 bits and sets that tag to valid.
- R6: A pop or stack read of an entry whose tag is 11 raises `rsp_underflow` together with its response. Otherwise `rsp_underflow` is low.
- R7: Packed read returns the mantissa of entry `cmd_idx` in bits 63:0 of `rsp_data` with bits 79:64 zero. Packed write stores `cmd_data[63:0]` as the mantissa of entry `cmd_idx`, sets the exponent to FFFF, and ignores `cmd_data[79:64]`.
- R8: Packed write sets all eight tags to 00 and the top pointer to 0.
- R9: The empty command sets all eight tags to 11 in the cycle it is taken. It also clears the view history, so the next command of either view pays no switching penalty.
- R10: When a stack command (1 to 4) arrives after packed use, or a packed command (5, 6) arrives after stack use, `switch_stall` is high and `cmd_ready` low for exactly PENALTY cycles (default 2) before the command is taken. Later commands of the same view pay no penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_idx | input | 3 | Stack offset or flat register index |
| cmd_data | input | 80 | Write data |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 80 | Read result |
| rsp_underflow | output | 1 | Result came from an empty stack entry |
| switch_stall | output | 1 | View-switch penalty in progress |
| stack_top | output | 3 | Current top-of-stack pointer |
| tag_bits | output | 16 | Tags of all entries, two bits each |

## Verification
A wrong top pointer shows on `stack_top` one cycle after the push, pop or packed write that moved it. It also shows on the next relative read, because that read returns the wrong entry or a false underflow. Tag errors appear on `tag_bits` right after the command that set them, and a later read reports them through `rsp_underflow`. A fault in the view history shows up as a wrong number of cycles with `cmd_ready` low in front of the first command after a switch, or in front of a command that follows an empty command.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_FPUSH  = 3'd1,
    OP_FPOP   = 3'd2,
    OP_FREAD  = 3'd3,
    OP_FWRITE = 3'd4,
    OP_PREAD  = 3'd5,
    OP_PWRITE = 3'd6,
    OP_EMPTY  = 3'd7
  } arf_op_e;

  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_FP   = 2'd1,
    VIEW_PK   = 2'd2
  } arf_view_e;

  typedef enum logic [2:0] {
    TC_HOLD      = 3'd0,
    TC_ONE_VALID = 3'd1,
    TC_ONE_EMPTY = 3'd2,
    TC_ALL_VALID = 3'd3,
    TC_ALL_EMPTY = 3'd4
  } arf_tagcmd_e;

  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;

  function automatic arf_view_e view_of(input arf_op_e op);
    case (op)
      OP_FPUSH, OP_FPOP, OP_FREAD, OP_FWRITE: view_of = VIEW_FP;
      OP_PREAD, OP_PWRITE:                    view_of = VIEW_PK;
      default:                                view_of = VIEW_NONE;
    endcase
  endfunction
endpackage

// File: rtl/arf_storage.sv
module arf_storage
  import arf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WORD_W  = 80,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  arf_tagcmd_e       tag_cmd,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_empty,
  output logic [2*ENTRIES-1:0] tag_bits
);
  logic [WORD_W-1:0] words [ENTRIES];
  logic [1:0]        tags  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[g] <= '0;
        tags[g]  <= TAG_EMPTY;
      end else begin
        if (wr_en && wr_idx == IDX_W'(g)) words[g] <= wr_word;
        case (tag_cmd)
          TC_ALL_VALID: tags[g] <= TAG_VALID;
          TC_ALL_EMPTY: tags[g] <= TAG_EMPTY;
          TC_ONE_VALID: if (tag_idx == IDX_W'(g)) tags[g] <= TAG_VALID;
          TC_ONE_EMPTY: if (tag_idx == IDX_W'(g)) tags[g] <= TAG_EMPTY;
          default: ;
        endcase
      end
    end
    assign tag_bits[2*g +: 2] = tags[g];
  end

  assign rd_word  = words[rd_idx];
  assign rd_empty = (tags[rd_idx] == TAG_EMPTY);
endmodule

// File: rtl/arf_view_ctrl.sv
module arf_view_ctrl
  import arf_pkg::*;
#(
  parameter int PENALTY = 2,
  localparam int CNT_W  = $clog2(PENALTY + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_valid,
  input  arf_op_e cmd_op,
  input  logic    accept,
  output logic    stall
);
  arf_view_e        last_view;
  logic [CNT_W-1:0] remain;
  arf_view_e        want;
  logic             mismatch;

  always_comb begin
    want     = view_of(cmd_op);
    mismatch = cmd_valid && want != VIEW_NONE && last_view != VIEW_NONE
               && want != last_view;
  end

  assign stall = mismatch || (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_view <= VIEW_NONE;
      remain    <= '0;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else if (mismatch) begin
      last_view <= want;
      remain    <= CNT_W'(PENALTY - 1);
    end else if (accept) begin
      if (cmd_op == OP_EMPTY)      last_view <= VIEW_NONE;
      else if (want != VIEW_NONE)  last_view <= want;
    end
  end
endmodule

// File: rtl/aliasreg_file.sv
module aliasreg_file
  import arf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int MANT_W  = 64,
  parameter int EXP_W   = 16,
  parameter int PENALTY = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WORD_W = MANT_W + EXP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [2:0]           cmd_op,
  input  logic [IDX_W-1:0]     cmd_idx,
  input  logic [WORD_W-1:0]    cmd_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_W-1:0]    rsp_data,
  output logic                 rsp_underflow,
  output logic                 switch_stall,
  output logic [IDX_W-1:0]     stack_top,
  output logic [2*ENTRIES-1:0] tag_bits
);
  arf_op_e           op;
  logic              accept;
  logic [IDX_W-1:0]  tos;
  logic [IDX_W-1:0]  rel_idx, below_idx;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx, tag_idx;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              rd_empty;
  arf_tagcmd_e       tag_cmd;
  logic              is_read;

  assign op        = arf_op_e'(cmd_op);
  assign cmd_ready = !switch_stall && (!rsp_valid || rsp_ready);
  assign accept    = cmd_valid && cmd_ready;
  assign rel_idx   = tos + cmd_idx;
  assign below_idx = tos - 1'b1;
  assign stack_top = tos;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = cmd_idx;
    wr_word = cmd_data;
    rd_idx  = cmd_idx;
    tag_idx = cmd_idx;
    tag_cmd = TC_HOLD;
    is_read = 1'b0;
    case (op)
      OP_FPUSH: begin
        wr_en = accept; wr_idx = below_idx; tag_idx = below_idx;
        tag_cmd = accept ? TC_ONE_VALID : TC_HOLD;
      end
      OP_FWRITE: begin
        wr_en = accept; wr_idx = rel_idx; tag_idx = rel_idx;
        tag_cmd = accept ? TC_ONE_VALID : TC_HOLD;
      end
      OP_FPOP: begin
        rd_idx = tos; tag_idx = tos; is_read = 1'b1;
        tag_cmd = accept ? TC_ONE_EMPTY : TC_HOLD;
      end
      OP_FREAD: begin
        rd_idx = rel_idx; is_read = 1'b1;
      end
      OP_PREAD: is_read = 1'b1;
      OP_PWRITE: begin
        wr_en   = accept;
        wr_word = {{EXP_W{1'b1}}, cmd_data[MANT_W-1:0]};
        tag_cmd = accept ? TC_ALL_VALID : TC_HOLD;
      end
      OP_EMPTY: tag_cmd = accept ? TC_ALL_EMPTY : TC_HOLD;
      default: ;
    endcase
  end

  arf_storage #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .tag_cmd(tag_cmd), .tag_idx(tag_idx),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_empty(rd_empty),
    .tag_bits(tag_bits)
  );

  arf_view_ctrl #(.PENALTY(PENALTY)) u_view (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(op), .accept(accept),
    .stall(switch_stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos <= '0;
    end else if (accept) begin
      case (op)
        OP_FPUSH:  tos <= below_idx;
        OP_FPOP:   tos <= tos + 1'b1;
        OP_PWRITE: tos <= '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_underflow <= 1'b0;
    end else if (accept && is_read) begin
      rsp_valid <= 1'b1;
      if (op == OP_PREAD) begin
        rsp_data      <= {{EXP_W{1'b0}}, rd_word[MANT_W-1:0]};
        rsp_underflow <= 1'b0;
      end else begin
        rsp_data      <= rd_word;
        rsp_underflow <= rd_empty;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/arf_checker.sv
module arf_checker
  import arf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WORD_W  = 80,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [2:0]           cmd_op,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [WORD_W-1:0]    rsp_data,
  input logic                 switch_stall,
  input logic [IDX_W-1:0]     stack_top,
  input logic [2*ENTRIES-1:0] tag_bits
);
  logic      taken;
  arf_view_e seen_view, op_view;
  logic      crosses;

  assign taken   = cmd_valid && cmd_ready;
  assign op_view = view_of(arf_op_e'(cmd_op));
  assign crosses = taken && op_view != VIEW_NONE && seen_view != VIEW_NONE
                   && op_view != seen_view;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_view <= VIEW_NONE;
    else if (taken) begin
      if (cmd_op == OP_EMPTY)         seen_view <= VIEW_NONE;
      else if (op_view != VIEW_NONE)  seen_view <= op_view;
    end
  end

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cmd_op == OP_FPUSH |=> stack_top == IDX_W'($past(stack_top) - 1'b1));

  p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cmd_op == OP_FPOP |=> rsp_valid && stack_top == IDX_W'($past(stack_top) + 1'b1));

  p_pk_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cmd_op == OP_PWRITE |=> tag_bits == '0 && stack_top == '0);

  p_empty_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cmd_op == OP_EMPTY |=> &tag_bits);

  p_switch_paid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    crosses |-> $past(switch_stall));
endmodule

bind aliasreg_file arf_checker #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_arf_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .switch_stall(switch_stall), .stack_top(stack_top),
  .tag_bits(tag_bits)
);

// File: tb/tb_aliasreg_file.sv
module tb_aliasreg_file;
  localparam int VW = 173;
  localparam int NV = 14;
  localparam logic [79:0] VA = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] VB = 80'hC000_C000_0000_0000_0000;
  localparam logic [79:0] VC = 80'h4005_1234_5678_90AB_CDEF;
  localparam logic [63:0] VD = 64'hA5A5_0F0F_F0F0_5A5A;
  // {op, idx, data, has_rsp, exp_data, exp_uf, exp_tos, exp_stall}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd1, 3'd0, VA,               1'b0, 80'h0,               1'b0, 3'd7, 2'd0}, // R3 wrap
    {3'd1, 3'd0, VB,               1'b0, 80'h0,               1'b0, 3'd6, 2'd0}, // R3
    {3'd3, 3'd0, 80'h0,            1'b1, VB,                  1'b0, 3'd6, 2'd0}, // R5
    {3'd3, 3'd1, 80'h0,            1'b1, VA,                  1'b0, 3'd6, 2'd0}, // R5
    {3'd3, 3'd2, 80'h0,            1'b1, 80'h0,               1'b1, 3'd6, 2'd0}, // R6
    {3'd4, 3'd1, VC,               1'b0, 80'h0,               1'b0, 3'd6, 2'd0}, // R5
    {3'd2, 3'd0, 80'h0,            1'b1, VB,                  1'b0, 3'd7, 2'd0}, // R4
    {3'd2, 3'd0, 80'h0,            1'b1, VC,                  1'b0, 3'd0, 2'd0}, // R4
    {3'd2, 3'd0, 80'h0,            1'b1, 80'h0,               1'b1, 3'd1, 2'd0}, // R6
    {3'd6, 3'd3, {16'h1234, VD},   1'b0, 80'h0,               1'b0, 3'd0, 2'd2}, // R7 R10
    {3'd5, 3'd3, 80'h0,            1'b1, {16'h0, VD},         1'b0, 3'd0, 2'd0}, // R7
    {3'd5, 3'd7, 80'h0,            1'b1, {16'h0, VC[63:0]},   1'b0, 3'd0, 2'd0}, // R7
    {3'd7, 3'd0, 80'h0,            1'b0, 80'h0,               1'b0, 3'd0, 2'd0}, // R9
    {3'd3, 3'd0, 80'h0,            1'b1, 80'h0,               1'b1, 3'd0, 2'd0}  // R9 R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] cmd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [79:0] rsp_data;
  logic        rsp_underflow;
  logic        switch_stall;
  logic [2:0]  stack_top;
  logic [15:0] tag_bits;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aliasreg_file dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_underflow(rsp_underflow), .switch_stall(switch_stall),
    .stack_top(stack_top), .tag_bits(tag_bits)
  );

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [2:0] idx,
                      input logic [79:0] data, output int stalls);
    stalls = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = data;
    #1;
    while (!cmd_ready) begin
      if (switch_stall) stalls++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int st;
    logic [79:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 top", 80'(stack_top), 80'd0);
    check("R1 tags", 80'(tag_bits), 80'hFFFF);
    check("R1 rsp_valid", 80'(rsp_valid), 80'd0);
    check("R1 cmd_ready", 80'(cmd_ready), 80'd1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      send(v[172:170], v[169:167], v[166:87], st);
      check($sformatf("R10 stall row %0d", i), 80'(st), 80'(v[1:0]));
      check($sformatf("R3/R4 top row %0d", i), 80'(stack_top), 80'(v[4:2]));
      check($sformatf("R2 rsp_valid row %0d", i), 80'(rsp_valid), 80'(v[86]));
      if (v[86]) begin
        check($sformatf("R5/R7 data row %0d", i), rsp_data, v[85:6]);
        check($sformatf("R6 underflow row %0d", i), 80'(rsp_underflow), 80'(v[5]));
      end
    end

    check("R9 all tags empty", 80'(tag_bits), 80'hFFFF);

    send(3'd1, 3'd0, VA, st);
    check("R3 tag entry7 valid", 80'(tag_bits[15:14]), 80'd0);
    check("R10 same view no stall", 80'(st), 80'd0);

    send(3'd6, 3'd0, 80'h0, st);
    check("R10 switch stall count", 80'(st), 80'd2);
    check("R8 tags valid", 80'(tag_bits), 80'h0);
    check("R8 top reset", 80'(stack_top), 80'd0);

    send(3'd7, 3'd0, 80'h0, st);
    send(3'd1, 3'd0, VB, st);
    check("R9 no penalty after empty", 80'(st), 80'd0);

    rsp_ready = 1'b0;
    send(3'd3, 3'd0, 80'h0, st);
    held = rsp_data;
    check("R2 rsp raised", 80'(rsp_valid), 80'd1);
    repeat (3) @(negedge clk);
    #1;
    check("R2 rsp held", 80'(rsp_valid), 80'd1);
    check("R2 data stable", rsp_data, held);
    check("R2 data value", rsp_data, VB);
    check("R2 ready low", 80'(cmd_ready), 80'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    #1;
    check("R2 rsp released", 80'(rsp_valid), 80'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule